// File: doc/BRIEF.md
# Single-Frame Register-Mapped Network Buffer

The block is a small network interface that a host drives through a 6-bit register bus with one-cycle read and write strobes and 32-bit data. It holds exactly one received frame and assembles exactly one outgoing frame. Each frame lives in its own byte buffer of `FRAME_MAX_P` bytes (1514 by default). Received bytes enter on a byte stream with valid, last and ready. Outgoing frames leave on a second byte stream of the same shape. The host moves payload one byte per access through two data-port registers.

A busy flag blocks reception. It is set when a frame is captured or sent, and by reset. It is recomputed on every write to the interrupt-control register. The interrupt-control register holds three flags: TX-done, RX-done and a self-test bit. The interrupt line is high whenever any of the three is set. Writing the self-test bit performs a soft reset of counts, pointers and flags, and then raises the self-test bit. That bit clears when the host reads interrupt control.

Read data appears on `rdata_o` one cycle after the `rd_i` strobe and holds until the next read. Read side effects take effect at that same clock edge. `rd_i` and `wr_i` are never asserted together.

Top module: `fbuf_nic`

## Requirements
- R1: After `rst_ni` is released, busy reads 1, both byte counts read 0, interrupt control reads 0, `irq_o` is low, `rx_ready_o` is low and `tx_valid_o` is low.
- R2: Offset 0x00 reads 0x4D495053 and offset 0x04 reads 0x4E455430. Offset 0x18, offset 0x20 and every offset not listed in R3 to R13 read 0. The register offsets are: busy 0x08, receive count 0x0C, transmit count 0x10, interrupt control 0x14, receive data 0x1C, transmit data 0x20.
- R3: Writes to offsets 0x00, 0x08, 0x0C, 0x18 and 0x1C change no register.
- R4: In interrupt control, bit 0 is TX-done, bit 1 is RX-done and bit 31 is the self-test bit. All other bits read 0. `irq_o` is high exactly when this register is nonzero.
- R5: A write to interrupt control is decoded by priority. If data bit 0 is set, only TX-done clears. Otherwise, if data bit 1 is set, only RX-done clears. Otherwise, if data bit 31 is set, a soft reset runs and then the self-test bit is set. A write of zero leaves the flags unchanged. After any such write, busy equals 1 when the register is nonzero and 0 otherwise.
- R6: Reading interrupt control returns its value and then clears only the self-test bit. The read does not change busy.
- R7: Writing the transmit count loads the value if it is at most 1514 and loads 0 otherwise. The same write returns the transmit write pointer to 0.
- R8: Each write to the transmit data port stores bits 7:0 at the write pointer and advances the pointer. When the pointer reaches the transmit count, or reaches 1514, the frame is sent. Sending clears the count and the pointer, sets TX-done and sets busy.
- R9: The transmit stream presents bytes 0 to N-1 in order and asserts `tx_last_o` on byte N-1. Byte, last flag and valid stay steady while `tx_ready_i` is low. Transmit data-port writes made while a frame is still leaving are ignored.
- R10: Between frames, `rx_ready_o` is high only when busy is 0 and the receive count is below 1514.
- R11: An accepted frame of N bytes (N < 1514) loads the receive count with N, resets the read pointer, sets RX-done and sets busy.
- R12: A frame of 1514 bytes or more is taken from the stream to its last byte and then discarded. Busy, the receive count and RX-done stay unchanged.
- R13: A read of the receive data port with a nonzero count returns the byte at the read pointer, decrements the count and advances the pointer. With a zero count the read returns 0 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 6 | Register byte offset |
| rd_i | input | 1 | One-cycle read strobe |
| wr_i | input | 1 | One-cycle write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after `rd_i` |
| irq_o | output | 1 | Level interrupt |
| rx_data_i | input | 8 | Receive stream byte |
| rx_valid_i | input | 1 | Receive byte valid |
| rx_last_i | input | 1 | Final byte of the received frame |
| rx_ready_o | output | 1 | Block accepts the receive byte |
| tx_data_o | output | 8 | Transmit stream byte |
| tx_valid_o | output | 1 | Transmit byte valid |
| tx_last_o | output | 1 | Final byte of the transmitted frame |
| tx_ready_i | input | 1 | Sink accepts the transmit byte |

## Verification
Every register effect lands at the clock edge that samples the strobe. The bench therefore drives a strobe at one falling edge and reads `rdata_o`, `irq_o` or `rx_ready_o` at the next falling edge, exactly one cycle later. A received frame completes at the edge that takes its last byte, so its count and flags are read back on the first bus access after the stream task returns. Transmit bytes are scored at the falling edge before the rising edge that transfers them, so stalls never shift the comparison.

// File: rtl/fbuf_pkg.sv
package fbuf_pkg;
  localparam int unsigned FRAME_MAX = 1514;

  localparam logic [5:0] A_ID0   = 6'h00;
  localparam logic [5:0] A_ID1   = 6'h04;
  localparam logic [5:0] A_BUSY  = 6'h08;
  localparam logic [5:0] A_RXCNT = 6'h0C;
  localparam logic [5:0] A_TXCNT = 6'h10;
  localparam logic [5:0] A_ICTL  = 6'h14;
  localparam logic [5:0] A_INFO  = 6'h18;
  localparam logic [5:0] A_RXDAT = 6'h1C;
  localparam logic [5:0] A_TXDAT = 6'h20;

  localparam logic [31:0] ID_WORD0 = 32'h4D49_5053;
  localparam logic [31:0] ID_WORD1 = 32'h4E45_5430;

  typedef enum logic [1:0] {RX_IDLE, RX_FILL, RX_DRAIN} rx_state_e;

  typedef struct packed {
    logic test;
    logic rx_done;
    logic tx_done;
  } ictl_t;
endpackage

// File: rtl/fbuf_rx.sv
module fbuf_rx
  import fbuf_pkg::*;
#(
  parameter int unsigned DEPTH = FRAME_MAX,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          soft_rst_i,
  input  logic          busy_i,
  input  logic          pop_i,
  input  logic [7:0]    s_data_i,
  input  logic          s_valid_i,
  input  logic          s_last_i,
  output logic          s_ready_o,
  output logic [CW-1:0] count_o,
  output logic [7:0]    byte_o,
  output logic          commit_o
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [CW-1:0] len_q, rptr_q, count_q;
  rx_state_e     st_q;
  logic          hs, full_hit, store, mid_frame;

  assign s_ready_o = (st_q == RX_IDLE) ? (!busy_i && count_q < CW'(DEPTH)) : 1'b1;
  assign hs        = s_valid_i && s_ready_o;
  // byte at index DEPTH-1 makes the frame too long
  assign full_hit  = (len_q == CW'(DEPTH - 1));
  assign store     = hs && st_q != RX_DRAIN && !full_hit;
  assign commit_o  = store && s_last_i && !soft_rst_i;
  assign mid_frame = hs ? (!s_last_i && st_q != RX_DRAIN) : (st_q == RX_FILL);

  assign count_o = count_q;
  assign byte_o  = (count_q != '0) ? mem[rptr_q[AW-1:0]] : 8'h00;

  always_ff @(posedge clk_i) begin
    if (store) mem[len_q[AW-1:0]] <= s_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= RX_IDLE;
      len_q   <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else begin
      if (pop_i && count_q != '0) begin
        count_q <= count_q - 1'b1;
        rptr_q  <= rptr_q + 1'b1;
      end
      case (st_q)
        RX_IDLE, RX_FILL: begin
          if (hs) begin
            if (full_hit) begin
              st_q  <= s_last_i ? RX_IDLE : RX_DRAIN;
              len_q <= '0;
            end else if (s_last_i) begin
              st_q  <= RX_IDLE;
              len_q <= '0;
              if (!soft_rst_i) begin
                count_q <= len_q + 1'b1;
                rptr_q  <= '0;
              end
            end else begin
              st_q  <= RX_FILL;
              len_q <= len_q + 1'b1;
            end
          end
        end
        RX_DRAIN: if (hs && s_last_i) st_q <= RX_IDLE;
        default:  st_q <= RX_IDLE;
      endcase
      if (soft_rst_i) begin
        count_q <= '0;
        rptr_q  <= '0;
        if (mid_frame) begin
          st_q  <= RX_DRAIN;
          len_q <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/fbuf_tx.sv
module fbuf_tx #(
  parameter int unsigned DEPTH = 1514,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          soft_rst_i,
  input  logic          cnt_we_i,
  input  logic          dat_we_i,
  input  logic [31:0]   wdata_i,
  output logic [CW-1:0] count_o,
  output logic          send_o,
  output logic [7:0]    m_data_o,
  output logic          m_valid_o,
  output logic          m_last_o,
  input  logic          m_ready_i
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [CW-1:0] count_q, wptr_q, len_q, idx_q, nxt;
  logic          sending_q, take;

  assign nxt    = wptr_q + 1'b1;
  assign take   = dat_we_i && !sending_q;
  assign send_o = take && (nxt == CW'(DEPTH) || nxt == count_q);

  assign count_o   = count_q;
  assign m_valid_o = sending_q;
  assign m_data_o  = mem[idx_q[AW-1:0]];
  assign m_last_o  = sending_q && (idx_q == len_q - 1'b1);

  always_ff @(posedge clk_i) begin
    if (take) mem[wptr_q[AW-1:0]] <= wdata_i[7:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q   <= '0;
      wptr_q    <= '0;
      len_q     <= '0;
      idx_q     <= '0;
      sending_q <= 1'b0;
    end else begin
      if (sending_q && m_ready_i) begin
        if (m_last_o) sending_q <= 1'b0;
        else          idx_q     <= idx_q + 1'b1;
      end
      if (cnt_we_i) begin
        count_q <= (wdata_i <= 32'(DEPTH)) ? wdata_i[CW-1:0] : '0;
        wptr_q  <= '0;
      end else if (take) begin
        if (send_o) begin
          count_q   <= '0;
          wptr_q    <= '0;
          len_q     <= nxt;
          idx_q     <= '0;
          sending_q <= 1'b1;
        end else begin
          wptr_q <= nxt;
        end
      end
      if (soft_rst_i) begin
        count_q <= '0;
        wptr_q  <= '0;
      end
    end
  end
endmodule

// File: rtl/fbuf_ctl.sv
module fbuf_ctl
  import fbuf_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rd_i,
  input  logic       wr_i,
  input  logic [2:0] wbits_i,   // {bit31, bit1, bit0} of write data
  input  logic       rx_commit_i,
  input  logic       tx_send_i,
  output ictl_t      ictl_o,
  output logic       busy_o,
  output logic       irq_o,
  output logic       soft_rst_o
);
  ictl_t q, d;
  logic  busy_q, busy_d;

  assign soft_rst_o = wr_i && !wbits_i[0] && !wbits_i[1] && wbits_i[2];

  always_comb begin
    d      = q;
    busy_d = busy_q;
    if (rd_i) d.test = 1'b0;
    if (wr_i) begin
      if (wbits_i[0])      d.tx_done = 1'b0;
      else if (wbits_i[1]) d.rx_done = 1'b0;
      else if (wbits_i[2]) d = '{test: 1'b1, default: 1'b0};
    end
    if (rx_commit_i) d.rx_done = 1'b1;
    if (tx_send_i)   d.tx_done = 1'b1;
    if (wr_i)                          busy_d = d.test | d.rx_done | d.tx_done;
    else if (rx_commit_i || tx_send_i) busy_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q      <= '0;
      busy_q <= 1'b1;
    end else begin
      q      <= d;
      busy_q <= busy_d;
    end
  end

  assign ictl_o = q;
  assign busy_o = busy_q;
  assign irq_o  = q.test | q.rx_done | q.tx_done;
endmodule

// File: rtl/fbuf_nic.sv
module fbuf_nic
  import fbuf_pkg::*;
#(
  parameter int unsigned FRAME_MAX_P = FRAME_MAX
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [5:0]  addr_i,
  input  logic        rd_i,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        irq_o,
  input  logic [7:0]  rx_data_i,
  input  logic        rx_valid_i,
  input  logic        rx_last_i,
  output logic        rx_ready_o,
  output logic [7:0]  tx_data_o,
  output logic        tx_valid_o,
  output logic        tx_last_o,
  input  logic        tx_ready_i
);
  localparam int unsigned CW = $clog2(FRAME_MAX_P + 1);

  ictl_t         ictl;
  logic [31:0]   ictl_word, rd_mux, rdata_q;
  logic [CW-1:0] rx_count, tx_count;
  logic [7:0]    rx_byte;
  logic          busy, soft_rst, rx_commit, tx_send;

  fbuf_ctl u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_i       (rd_i && addr_i == A_ICTL),
    .wr_i       (wr_i && addr_i == A_ICTL),
    .wbits_i    ({wdata_i[31], wdata_i[1], wdata_i[0]}),
    .rx_commit_i(rx_commit),
    .tx_send_i  (tx_send),
    .ictl_o     (ictl),
    .busy_o     (busy),
    .irq_o      (irq_o),
    .soft_rst_o (soft_rst)
  );

  fbuf_rx #(.DEPTH(FRAME_MAX_P), .CW(CW)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .soft_rst_i(soft_rst),
    .busy_i    (busy),
    .pop_i     (rd_i && addr_i == A_RXDAT),
    .s_data_i  (rx_data_i),
    .s_valid_i (rx_valid_i),
    .s_last_i  (rx_last_i),
    .s_ready_o (rx_ready_o),
    .count_o   (rx_count),
    .byte_o    (rx_byte),
    .commit_o  (rx_commit)
  );

  fbuf_tx #(.DEPTH(FRAME_MAX_P), .CW(CW)) u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .soft_rst_i(soft_rst),
    .cnt_we_i  (wr_i && addr_i == A_TXCNT),
    .dat_we_i  (wr_i && addr_i == A_TXDAT),
    .wdata_i   (wdata_i),
    .count_o   (tx_count),
    .send_o    (tx_send),
    .m_data_o  (tx_data_o),
    .m_valid_o (tx_valid_o),
    .m_last_o  (tx_last_o),
    .m_ready_i (tx_ready_i)
  );

  assign ictl_word = {ictl.test, 29'b0, ictl.rx_done, ictl.tx_done};

  always_comb begin
    case (addr_i)
      A_ID0:   rd_mux = ID_WORD0;
      A_ID1:   rd_mux = ID_WORD1;
      A_BUSY:  rd_mux = {31'b0, busy};
      A_RXCNT: rd_mux = 32'(rx_count);
      A_TXCNT: rd_mux = 32'(tx_count);
      A_ICTL:  rd_mux = ictl_word;
      A_RXDAT: rd_mux = {24'b0, rx_byte};
      default: rd_mux = 32'h0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/fbuf_nic_chk.sv
module fbuf_nic_chk
  import fbuf_pkg::*;
#(
  parameter int unsigned DEPTH = FRAME_MAX,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [5:0]    addr_i,
  input logic          rd_i,
  input logic          wr_i,
  input logic          busy_i,
  input logic [31:0]   ictl_i,
  input logic [CW-1:0] rx_count_i,
  input logic [CW-1:0] tx_count_i,
  input logic          rx_commit_i,
  input logic          tx_send_i,
  input logic          rx_ready_i,
  input logic [7:0]    tx_data_i,
  input logic          tx_valid_i,
  input logic          tx_last_i,
  input logic          tx_ready_i
);
  p_rx_count_bound_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_count_i < CW'(DEPTH));

  p_tx_count_cap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_count_i <= CW'(DEPTH));

  p_commit_flags_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_commit_i |=> busy_i && ictl_i[1] && rx_count_i != '0);

  p_send_flags_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_send_i |=> busy_i && ictl_i[0] && tx_count_i == '0);

  p_ictl_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_ICTL) |=> busy_i == (ictl_i != 32'h0));

  p_test_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && addr_i == A_ICTL) |=> !ictl_i[31]);

  p_tx_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_i && !tx_ready_i) |=> tx_valid_i && $stable(tx_data_i) && $stable(tx_last_i));

  p_rx_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_ready_i) |-> !busy_i && rx_count_i < CW'(DEPTH));
endmodule

bind fbuf_nic fbuf_nic_chk #(.DEPTH(FRAME_MAX_P), .CW(CW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .rd_i       (rd_i),
  .wr_i       (wr_i),
  .busy_i     (busy),
  .ictl_i     (ictl_word),
  .rx_count_i (rx_count),
  .tx_count_i (tx_count),
  .rx_commit_i(rx_commit),
  .tx_send_i  (tx_send),
  .rx_ready_i (rx_ready_o),
  .tx_data_i  (tx_data_o),
  .tx_valid_i (tx_valid_o),
  .tx_last_i  (tx_last_o),
  .tx_ready_i (tx_ready_i)
);

// File: tb/sim_fbuf_nic.sv
module sim_fbuf_nic;
  import fbuf_pkg::*;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [5:0]  addr = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_o;
  logic        irq_o;
  logic [7:0]  rx_data = '0;
  logic        rx_valid = 1'b0, rx_last = 1'b0;
  logic        rx_ready_o;
  logic [7:0]  tx_data_o;
  logic        tx_valid_o, tx_last_o;
  logic        tx_ready = 1'b0;

  int n_chk = 0;
  int n_err = 0;
  logic [8:0] exp_q[$];
  logic stall_en = 1'b0;
  logic tx_go = 1'b1;
  int cyc = 0;

  always #2 clk = ~clk;

  fbuf_nic u0 (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata_o), .irq_o(irq_o),
    .rx_data_i(rx_data), .rx_valid_i(rx_valid), .rx_last_i(rx_last), .rx_ready_o(rx_ready_o),
    .tx_data_o(tx_data_o), .tx_valid_o(tx_valid_o), .tx_last_o(tx_last_o), .tx_ready_i(tx_ready)
  );

  function automatic logic [7:0] pat(logic [7:0] s, int i);
    return s + 8'(i * 13);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata_o;
  endtask

  task automatic rd_chk(string req, logic [5:0] a, logic [31:0] exp);
    logic [31:0] v;
    bus_rd(a, v);
    check(req, v, exp);
  endtask

  task automatic rx_send(int n, logic [7:0] s);
    int i = 0;
    while (i < n) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = pat(s, i); rx_last = (i == n - 1);
      #1;
      if (rx_ready_o) i++;
    end
    @(negedge clk); rx_valid = 1'b0; rx_last = 1'b0;
  endtask

  // driver: queue expected stream items, then write the bytes
  task automatic tx_frame(int n, logic [7:0] s);
    for (int i = 0; i < n; i++) exp_q.push_back({(i == n - 1), pat(s, i)});
    for (int i = 0; i < n; i++) bus_wr(A_TXDAT, {24'hA5C3E1, pat(s, i)});
  endtask

  task automatic tx_drain(string req);
    int t = 0;
    while (exp_q.size() != 0 && t < 20000) begin @(negedge clk); t++; end
    repeat (2) @(negedge clk);
    check(req, {31'b0, tx_valid_o}, 32'h0);
    check(req, exp_q.size(), 32'h0);
  endtask

  // sink ready pattern, changed just after each rising edge
  initial begin
    forever begin
      @(posedge clk); #1;
      cyc++;
      tx_ready = stall_en ? (cyc % 3 != 0) : tx_go;
    end
  end

  // monitor: score each byte the cycle it is offered with ready high
  always @(negedge clk) begin
    if (rst_ni && tx_valid_o && tx_ready) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_err++;
        $display("FAIL R9 actual=%h expected=none", {tx_last_o, tx_data_o});
      end else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        if ({tx_last_o, tx_data_o} !== e) begin
          n_err++;
          $display("FAIL R9 actual=%h expected=%h", {tx_last_o, tx_data_o}, e);
        end
      end
    end
  end

  initial begin
    #(4 * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", {31'b0, irq_o}, 0);
    check("R1 rx_ready", {31'b0, rx_ready_o}, 0);
    check("R1 tx_valid", {31'b0, tx_valid_o}, 0);
    rd_chk("R1 busy", A_BUSY, 1);
    rd_chk("R1 rxcnt", A_RXCNT, 0);
    rd_chk("R1 txcnt", A_TXCNT, 0);
    rd_chk("R1 ictl", A_ICTL, 0);
    // R2 fixed reads
    rd_chk("R2 id0", A_ID0, 32'h4D495053);
    rd_chk("R2 id1", A_ID1, 32'h4E455430);
    rd_chk("R2 info", A_INFO, 0);
    rd_chk("R2 txdat", A_TXDAT, 0);
    rd_chk("R2 unmapped", 6'h3C, 0);
    rd_chk("R2 unaligned", 6'h02, 0);
    // R5 zero write recomputes busy
    bus_wr(A_ICTL, 0);
    rd_chk("R5 busy after zero write", A_BUSY, 0);
    check("R10 ready when idle", {31'b0, rx_ready_o}, 1);
    // R3 writes to read-only offsets
    bus_wr(A_BUSY, 1);
    bus_wr(A_RXCNT, 7);
    bus_wr(A_ID0, 32'hFFFF_FFFF);
    bus_wr(A_INFO, 5);
    bus_wr(A_RXDAT, 9);
    rd_chk("R3 busy", A_BUSY, 0);
    rd_chk("R3 rxcnt", A_RXCNT, 0);
    rd_chk("R3 id0", A_ID0, 32'h4D495053);
    rd_chk("R3 ictl", A_ICTL, 0);
    // R11 receive a 5-byte frame
    rx_send(5, 8'h21);
    rd_chk("R11 rxcnt", A_RXCNT, 5);
    rd_chk("R11 ictl rx-done", A_ICTL, 2);
    rd_chk("R11 busy", A_BUSY, 1);
    check("R4 irq on rx-done", {31'b0, irq_o}, 1);
    check("R10 ready low while busy", {31'b0, rx_ready_o}, 0);
    // R13 drain through the data port
    for (int i = 0; i < 5; i++) rd_chk("R13 rx byte", A_RXDAT, {24'b0, pat(8'h21, i)});
    rd_chk("R13 rxcnt empty", A_RXCNT, 0);
    rd_chk("R13 empty read", A_RXDAT, 0);
    rd_chk("R13 rxcnt stays", A_RXCNT, 0);
    // R5 priority
    bus_wr(A_ICTL, 32'h8000_0003);
    rd_chk("R5 bit0 wins", A_ICTL, 2);
    bus_wr(A_ICTL, 32'h8000_0002);
    rd_chk("R5 bit1 clears rx-done", A_ICTL, 0);
    rd_chk("R5 busy cleared", A_BUSY, 0);
    check("R4 irq low", {31'b0, irq_o}, 0);
    // R8 transmit 4 bytes with a stalling sink
    stall_en = 1'b1;
    bus_wr(A_TXCNT, 4);
    rd_chk("R7 txcnt load", A_TXCNT, 4);
    tx_frame(4, 8'h40);
    rd_chk("R8 tx-done", A_ICTL, 1);
    rd_chk("R8 busy", A_BUSY, 1);
    rd_chk("R8 txcnt cleared", A_TXCNT, 0);
    check("R4 irq on tx-done", {31'b0, irq_o}, 1);
    tx_drain("R9 frame4");
    bus_wr(A_ICTL, 1);
    rd_chk("R5 tx-done cleared", A_ICTL, 0);
    // R7 count limits and pointer reset
    bus_wr(A_TXCNT, 1515);
    rd_chk("R7 over limit", A_TXCNT, 0);
    bus_wr(A_TXCNT, 32'h0001_0003);
    rd_chk("R7 wide value", A_TXCNT, 0);
    bus_wr(A_TXCNT, 1514);
    rd_chk("R7 at limit", A_TXCNT, 1514);
    bus_wr(A_TXCNT, 3);
    bus_wr(A_TXDAT, 32'hEE);
    bus_wr(A_TXCNT, 2);
    tx_frame(2, 8'h60);
    tx_drain("R7 pointer reset");
    bus_wr(A_ICTL, 1);
    // R8 maximum-length frame with zero count
    stall_en = 1'b0; tx_go = 1'b1;
    bus_wr(A_TXCNT, 0);
    tx_frame(1514, 8'h11);
    rd_chk("R8 send at 1514", A_ICTL, 1);
    tx_drain("R8 frame1514");
    bus_wr(A_ICTL, 1);
    // R9 data writes during an active frame are ignored
    tx_go = 1'b0;
    bus_wr(A_TXCNT, 2);
    tx_frame(2, 8'h70);
    check("R9 frame held", {31'b0, tx_valid_o}, 1);
    bus_wr(A_TXCNT, 2);
    bus_wr(A_TXDAT, 32'hEE);
    tx_go = 1'b1;
    tx_drain("R9 held frame");
    tx_frame(2, 8'h80);
    tx_drain("R9 ignored write");
    bus_wr(A_ICTL, 1);
    rd_chk("R5 busy idle", A_BUSY, 0);
    // R12 oversize frames dropped
    rx_send(1520, 8'h33);
    rd_chk("R12 ictl", A_ICTL, 0);
    rd_chk("R12 rxcnt", A_RXCNT, 0);
    rd_chk("R12 busy", A_BUSY, 0);
    rx_send(1514, 8'h34);
    rd_chk("R12 exact limit ictl", A_ICTL, 0);
    rd_chk("R12 exact limit rxcnt", A_RXCNT, 0);
    check("R10 ready after drop", {31'b0, rx_ready_o}, 1);
    // R11 largest accepted frame
    rx_send(1513, 8'h35);
    rd_chk("R11 rxcnt 1513", A_RXCNT, 1513);
    rd_chk("R11 ictl", A_ICTL, 2);
    rd_chk("R13 byte0", A_RXDAT, {24'b0, pat(8'h35, 0)});
    rd_chk("R13 byte1", A_RXDAT, {24'b0, pat(8'h35, 1)});
    rd_chk("R13 rxcnt 1511", A_RXCNT, 1511);
    check("R10 blocked by busy", {31'b0, rx_ready_o}, 0);
    bus_wr(A_ICTL, 2);
    check("R10 ready with residual count", {31'b0, rx_ready_o}, 1);
    rx_send(3, 8'h50);
    rd_chk("R11 overwrite count", A_RXCNT, 3);
    rd_chk("R11 pointer reset", A_RXDAT, {24'b0, pat(8'h50, 0)});
    // R5 soft reset through the test bit, R6 read clears it
    bus_wr(A_TXCNT, 5);
    bus_wr(A_ICTL, 32'h8000_0000);
    check("R4 irq on test bit", {31'b0, irq_o}, 1);
    check("R5 ready low after soft reset", {31'b0, rx_ready_o}, 0);
    rd_chk("R5 test bit set", A_ICTL, 32'h8000_0000);
    rd_chk("R6 test bit cleared", A_ICTL, 0);
    check("R6 irq low", {31'b0, irq_o}, 0);
    rd_chk("R6 busy kept", A_BUSY, 1);
    rd_chk("R5 rxcnt reset", A_RXCNT, 0);
    rd_chk("R5 txcnt reset", A_TXCNT, 0);
    bus_wr(A_ICTL, 0);
    rd_chk("R5 busy released", A_BUSY, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule